// File: doc/BRIEF.md
# Motor Direction Change Interlock

This block sits in front of a three-phase commutation decoder and turns a free-running, asynchronous direction request into a direction value that is safe to act on. The request is first brought into the system clock domain. A hold stage then accepts it only while the speed-low flag is high, so the motor cannot be reversed while it still stores a lot of energy. The held value then moves through a short shift chain. That chain advances only on the PWM clock-enable strobe, which guarantees a dead interval of at least one full PWM period before the decoder sees the new direction.

While any stage still disagrees with the stage feeding it, the block raises a registered inhibit that blanks every power driver. The motor therefore coasts through the change. Every edge of the request, in either direction, also produces a one-cycle pulse request for the tachometer logic, whatever the speed.

Top module: `dir_interlock`

## Requirements
- R1: While `rst` is high, the hold stage and every shift stage load the synchronized request, so `dirOut` follows `dirReq` after synchronization. The registered `inhibit` and `tachPulse` are 0 during reset and in the first cycle after it, provided `dirReq` was stable during reset.
- R2: `dirReq` passes through a two-flop synchronizer. A change applied between clock edges shows up on `tachPulse` in the cycle after the third rising edge that follows it.
- R3: The hold stage loads the synchronized request on a rising edge only when `speedLow` is 1 at that edge. Otherwise it keeps its value, and `dirOut` never takes up a request that arrived while `speedLow` was 0.
- R4: `dirOut` changes only on a rising edge at which `pwmTick` is 1. After the hold stage has taken a new value, exactly two `pwmTick` strobes are needed before `dirOut` shows it.
- R5: `inhibit` is 1 in the cycle after any edge at which the synchronized request differs from the hold stage, or the hold stage differs from `dirOut`. Otherwise it is 0.
- R6: Each change of the synchronized request, rising or falling, gives exactly one `tachPulse` that is one clock wide. This holds for both values of `speedLow`.
- R7: A request made while `speedLow` stays 0 keeps `inhibit` at 1 for as long as it stays pending, and `dirOut` does not change.
- R8: If a request is withdrawn before the hold stage takes it, two tach pulses are still produced. `inhibit` then returns to 0 and `dirOut` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dirReq | input | 1 | Asynchronous direction request (0 or 1) |
| speedLow | input | 1 | 1 when motor speed is low enough to allow a reversal |
| pwmTick | input | 1 | One-cycle strobe, once per PWM period |
| dirOut | output | 1 | Direction for the commutation decoder |
| inhibit | output | 1 | 1 blanks all power drivers |
| tachPulse | output | 1 | One-cycle tachometer pulse request |

## Verification
A request raised while `speedLow` is high, just after a PWM strobe, shows the synchronizer latency and the two-strobe shift. It also shows an inhibit window that opens and then closes. Holding `speedLow` low separates a working hold stage from a transparent one: the tach pulse must still occur while `dirOut` and the raised inhibit stay put. A request that is raised and then withdrawn during low-speed blocking, followed by a reset taken with the request high and a long stretch of random requests, speed flags and strobes, tells apart mismatch logic, edge detection and reset loading that are wrong.

// File: rtl/dir_interlock_pkg.sv
package dir_interlock_pkg;

  // Strobes passed from the control section to the datapath.
  typedef struct packed {
    logic dirSync;   // request after synchronization
    logic dirEdge;   // synchronized request changed this cycle
    logic latchEn;   // hold stage may follow its input
    logic shiftEn;   // shift chain advances
    logic loadAll;   // reset: every stage loads dirSync
  } dirStrb_t;

endpackage

// File: rtl/dir_interlock_ctrl.sv
module dir_interlock_ctrl
  import dir_interlock_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     dirReq,
  input  logic     speedLow,
  input  logic     pwmTick,
  output dirStrb_t strb
);

  localparam int SYNC_LAST = SYNC_DEPTH - 1;

  logic [SYNC_DEPTH-1:0] syncQ;
  logic                  dirPrev;
  logic                  dirSync;

  // Synchronizer chain; not reset, so it keeps tracking during reset.
  generate
    if (SYNC_DEPTH == 1) begin : g_sync1
      always_ff @(posedge clk) syncQ <= dirReq;
    end else begin : g_syncN
      always_ff @(posedge clk) syncQ <= {syncQ[SYNC_DEPTH-2:0], dirReq};
    end
  endgenerate

  assign dirSync = syncQ[SYNC_LAST];

  // Previous synchronized value, used for edge detection.
  always_ff @(posedge clk) begin
    dirPrev <= dirSync;
  end

  always_comb begin
    strb.dirSync = dirSync;
    strb.dirEdge = !rst && (dirSync != dirPrev);
    strb.latchEn = speedLow;
    strb.shiftEn = pwmTick;
    strb.loadAll = rst;
  end

  // R6: an edge is always reported; the latch enable plays no part in it.
  a_r6_edge_any_speed: assert property (@(posedge clk) disable iff (rst)
    (dirSync != dirPrev) |-> strb.dirEdge);

endmodule

// File: rtl/dir_interlock_dp.sv
module dir_interlock_dp
  import dir_interlock_pkg::*;
#(
  parameter int SHIFT_DEPTH = 2
) (
  input  logic     clk,
  input  dirStrb_t strb,
  output logic     dirOut,
  output logic     inhibit,
  output logic     tachPulse
);

  localparam int SHIFT_LAST = SHIFT_DEPTH - 1;

  logic                   latchQ;
  logic [SHIFT_DEPTH-1:0] shiftQ;
  logic                   latchMismatch;
  logic                   shiftMismatch;
  logic                   inhibitQ;
  logic                   tachQ;

  // Speed-gated hold stage.
  always_ff @(posedge clk) begin
    if (strb.loadAll || strb.latchEn) begin
      latchQ <= strb.dirSync;
    end
  end

  // Shift chain, advanced by the PWM strobe.
  generate
    if (SHIFT_DEPTH == 1) begin : g_shift1
      always_ff @(posedge clk) begin
        if (strb.loadAll)      shiftQ <= strb.dirSync;
        else if (strb.shiftEn) shiftQ <= latchQ;
      end
    end else begin : g_shiftN
      always_ff @(posedge clk) begin
        if (strb.loadAll)      shiftQ <= {SHIFT_DEPTH{strb.dirSync}};
        else if (strb.shiftEn) shiftQ <= {shiftQ[SHIFT_DEPTH-2:0], latchQ};
      end
    end
  endgenerate

  assign latchMismatch = strb.dirSync ^ latchQ;
  assign shiftMismatch = latchQ ^ shiftQ[SHIFT_LAST];

  always_ff @(posedge clk) begin
    if (strb.loadAll) begin
      inhibitQ <= 1'b0;
      tachQ    <= 1'b0;
    end else begin
      inhibitQ <= latchMismatch | shiftMismatch;
      tachQ    <= strb.dirEdge;
    end
  end

  assign dirOut    = shiftQ[SHIFT_LAST];
  assign inhibit   = inhibitQ;
  assign tachPulse = tachQ;

  a_r1_reset_quiet: assert property (@(posedge clk)
    strb.loadAll |=> (!inhibit && !tachPulse));

  a_r3_latch_hold: assert property (@(posedge clk) disable iff (strb.loadAll)
    !strb.latchEn |=> $stable(latchQ));

  a_r4_out_on_tick: assert property (@(posedge clk) disable iff (strb.loadAll)
    !strb.shiftEn |=> $stable(dirOut));

  a_r5_blank_on_mismatch: assert property (@(posedge clk) disable iff (strb.loadAll)
    (latchQ != dirOut) |=> inhibit);

  a_r6_tach_follows_edge: assert property (@(posedge clk) disable iff (strb.loadAll)
    strb.dirEdge |=> tachPulse);

endmodule

// File: rtl/dir_interlock.sv
module dir_interlock
  import dir_interlock_pkg::*;
#(
  parameter int SYNC_DEPTH  = 2,
  parameter int SHIFT_DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dirReq,
  input  logic speedLow,
  input  logic pwmTick,
  output logic dirOut,
  output logic inhibit,
  output logic tachPulse
);

  dirStrb_t strb;

  dir_interlock_ctrl #(.SYNC_DEPTH(SYNC_DEPTH)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .dirReq   (dirReq),
    .speedLow (speedLow),
    .pwmTick  (pwmTick),
    .strb     (strb)
  );

  dir_interlock_dp #(.SHIFT_DEPTH(SHIFT_DEPTH)) i_dp (
    .clk       (clk),
    .strb      (strb),
    .dirOut    (dirOut),
    .inhibit   (inhibit),
    .tachPulse (tachPulse)
  );

endmodule

// File: tb/test_dir_interlock.sv
`timescale 1ns/1ps
module test_dir_interlock;

  localparam int TICK = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dirReq = 1'b0;
  logic speedLow = 1'b1;
  logic pwmTick = 1'b0;
  logic dirOut, inhibit, tachPulse;

  int checks = 0;
  int errors = 0;
  bit compareOn = 0;

  always #2.5 clk = ~clk;

  dir_interlock i_dir_interlock (
    .clk(clk), .rst(rst), .dirReq(dirReq), .speedLow(speedLow),
    .pwmTick(pwmTick), .dirOut(dirOut), .inhibit(inhibit), .tachPulse(tachPulse)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkInt(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, updated on each rising edge.
  bit m1, m2, mPrev, mHold, mInh, mTach;
  bit mQ[$] = '{0, 0};   // front: first stage, back: output
  int tickCount = 0;
  bit countTicks = 0;

  always @(posedge clk) begin
    bit o1, o2, oPrev, oHold, oOut;
    o1 = m1; o2 = m2; oPrev = mPrev; oHold = mHold; oOut = mQ[1];
    m1 = dirReq;
    m2 = o1;
    mPrev = o2;
    if (rst) begin
      mHold = o2;
      mQ = '{o2, o2};
      mInh = 0;
      mTach = 0;
    end else begin
      if (speedLow) mHold = o2;
      if (pwmTick) begin
        mQ.push_front(oHold);
        void'(mQ.pop_back());
      end
      mInh = (o2 != oHold) || (oHold != oOut);
      mTach = (o2 != oPrev);
      if (countTicks && pwmTick) tickCount++;
    end
  end

  always @(negedge clk) begin
    if (compareOn && !rst) begin
      check("R4 dirOut vs model", dirOut, mQ[1]);
      check("R5 inhibit vs model", inhibit, mInh);
      check("R6 tachPulse vs model", tachPulse, mTach);
    end
  end

  // PWM strobe generator.
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        cnt = 0;
        pwmTick = 0;
      end else begin
        pwmTick = (cnt == TICK - 1);
        cnt = (cnt == TICK - 1) ? 0 : cnt + 1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit sawInh, sawTach;
    int pulses;
    repeat (6) @(negedge clk);
    check("R1 dirOut in reset", dirOut, 1'b0);
    check("R1 inhibit in reset", inhibit, 1'b0);
    check("R1 tachPulse in reset", tachPulse, 1'b0);
    rst = 0;
    compareOn = 1;
    @(negedge clk);
    check("R1 inhibit after reset", inhibit, 1'b0);

    // Request while speed is low: latency and two-strobe shift.
    @(posedge clk iff pwmTick);
    @(negedge clk);
    dirReq = 1;
    tickCount = 0;
    countTicks = 1;
    repeat (2) @(negedge clk);
    check("R2 no tach before third edge", tachPulse, 1'b0);
    @(negedge clk);
    check("R2 tach after third edge", tachPulse, 1'b1);
    @(negedge clk);
    check("R6 tach one cycle wide", tachPulse, 1'b0);
    sawInh = 0;
    for (int i = 0; i < 4 * TICK && dirOut != 1'b1; i++) begin
      @(negedge clk);
      if (inhibit) sawInh = 1;
    end
    countTicks = 0;
    check("R4 dirOut took new value", dirOut, 1'b1);
    checkInt("R4 strobes before change", tickCount, 2);
    check("R5 inhibit raised during change", sawInh, 1'b1);
    repeat (2) @(negedge clk);
    check("R5 inhibit clear after change", inhibit, 1'b0);

    // Speed high: change held off, tach still pulses.
    speedLow = 0;
    dirReq = 0;
    sawTach = 0;
    for (int i = 0; i < 5 * TICK; i++) begin
      @(negedge clk);
      if (tachPulse) sawTach = 1;
    end
    check("R6 tach at high speed", sawTach, 1'b1);
    check("R3 dirOut held at high speed", dirOut, 1'b1);
    check("R7 inhibit held while pending", inhibit, 1'b1);
    speedLow = 1;
    repeat (4 * TICK) @(negedge clk);
    check("R3 dirOut follows once speed low", dirOut, 1'b0);
    check("R5 inhibit clear after release", inhibit, 1'b0);

    // Request withdrawn while blocked.
    speedLow = 0;
    dirReq = 1;
    pulses = 0;
    repeat (5) begin @(negedge clk); if (tachPulse) pulses++; end
    dirReq = 0;
    repeat (10) begin @(negedge clk); if (tachPulse) pulses++; end
    checkInt("R8 two tach pulses", pulses, 2);
    check("R8 inhibit clears", inhibit, 1'b0);
    check("R8 dirOut unchanged", dirOut, 1'b0);
    speedLow = 1;

    // Reset with the request high.
    dirReq = 1;
    rst = 1;
    repeat (6) @(negedge clk);
    check("R1 dirOut loads request in reset", dirOut, 1'b1);
    check("R1 inhibit low in reset", inhibit, 1'b0);
    rst = 0;
    @(negedge clk);
    check("R1 inhibit low after reset", inhibit, 1'b0);
    check("R1 tach low after reset", tachPulse, 1'b0);

    // Random stimulus, compared against the model every cycle.
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 9) == 0) dirReq = ~dirReq;
      if ($urandom_range(0, 29) == 0) speedLow = ~speedLow;
    end
    speedLow = 1;
    repeat (4 * TICK) @(negedge clk);
    check("R3 settles with speed low", dirOut, dirReq);

    compareOn = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule